// File: doc/BRIEF.md
# Paged Command and Interrupt Register Block

This block is the host-facing control surface of a network interface controller. A single 8-bit command register sits at offset 0 on every register page. Writing it picks the active page, starts or halts the controller, launches a frame transmission and issues remote-DMA commands. The block also holds a 7-bit event status register and a matching enable mask, and it drives one interrupt line built from the two.

The host reaches the block through a simple synchronous port with a 4-bit offset. Which register an offset selects depends on the active page and on whether the access is a read or a write. The transmitter, receiver and DMA engine are outside this block. They appear only as single-cycle event pulses in, a frame-in-progress level in, and single-cycle command strobes out. The start, halt and transmit bits change state on their own in response to those internal events.

Top module: `nic_host_regs`

## Requirements
- R1: After synchronous reset, the command register reads 0x21 (halt bit set, DMA field 100, page 0). The status register reads 0x80, the mask reads 0x00, and irq, ctrl_run and all strobes are low.
- R2: The command register is read and written at offset 0 on all four pages. Its layout is: bit 0 halt, bit 1 start, bit 2 transmit-pending, bits 5:3 DMA command, bits 7:6 page select. Page values 00, 01 and 10 pick pages 0, 1 and 2; 11 is a reserved page.
- R3: The status register is read and write-1-cleared only at offset 7 on page 0. The mask is written only at offset 15 on page 0 and read only at offset 15 on page 2. Writes to these offsets on any other page have no effect.
- R4: A command write with bit 1 set and bit 0 clear sets the start bit, clears the halt bit, raises ctrl_run one cycle later, and clears status bit 7 from both of its causes.
- R5: A command write with bit 0 set clears start and sets halt at once, even if bit 1 is also set. Status bit 7 rises at the first clock edge, counting from that write, at which frame_busy is low.
- R6: A command write with bit 2 set, bit 0 clear, and either bit 1 set or the controller already running, sets transmit-pending and gives a one-cycle tx_launch. A tx_finish pulse clears transmit-pending, but a launch in the same cycle takes priority. If the controller is halted, the transmit bit has no effect.
- R7: Each command write decodes bits 5:3. If bit 5 is set, rdma_abort pulses for one cycle. Otherwise the values 001 (read), 010 (write) and 011 (send) pulse rdma_go with rdma_op equal to bits 4:3, and 000 gives no strobe. The pulse appears the cycle after the write.
- R8: evt_pulse[i] sets status bit i for i from 0 to 6. The bits mean: 0 frame received, 1 frame sent, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counter overflow, 6 DMA done. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle as a clearing write wins.
- R9: evt_pulse[4] also sets status bit 7. A ring_drained pulse clears that cause, but bit 7 stays set while the controller is in its halted reset state. The host cannot write bit 7.
- R10: Mask bits 6:0 are stored and bit 7 reads 0. irq is the OR over bits 0 to 6 of status AND mask. It is registered, so it changes at the same edge as the status or mask update that causes it.
- R11: Read data is registered. It appears the cycle after a read access and reflects the state before that edge. Unmapped offsets read 0x00, and the read data holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 selects a write, 0 a read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_pulse | input | 7 | Single-cycle status event pulses, bit i maps to status bit i |
| frame_busy | input | 1 | A frame is in progress; delays entry to the reset state |
| tx_finish | input | 1 | Transmission completed or aborted |
| ring_drained | input | 1 | At least one frame has been removed from the receive ring |
| irq | output | 1 | Interrupt request |
| ctrl_run | output | 1 | Controller started |
| tx_launch | output | 1 | One-cycle transmit command |
| rdma_go | output | 1 | One-cycle remote-DMA start command |
| rdma_op | output | 2 | DMA operation with rdma_go: 01 read, 10 write, 11 send |
| rdma_abort | output | 1 | One-cycle remote-DMA abort command |

## Verification
The bench builds the block with its defaults: seven event bits and a 4-bit offset. This makes the whole offset space reachable on all four page values, including the reserved page, and lets every status bit be driven on its own. Every ported output is compared against a behavioural model on each clock. The corner cases include an event landing on a clearing write, a halt held off by a busy frame, halt and start written together, and an overwrite still reported while the host tries to write bit 7.

// File: rtl/nhr_pkg.sv
package nhr_pkg;
  localparam int OFS_W = 4;
  localparam int EVT_N = 7;
  localparam int REG_W = EVT_N + 1;

  localparam logic [OFS_W-1:0] OFS_CMD  = 4'h0;
  localparam logic [OFS_W-1:0] OFS_STAT = 4'h7;
  localparam logic [OFS_W-1:0] OFS_MASK = 4'hF;

  localparam logic [2:0] DMA_IDLE = 3'b100;

  typedef enum logic [1:0] {
    PG_0   = 2'd0,
    PG_1   = 2'd1,
    PG_2   = 2'd2,
    PG_RSV = 2'd3
  } page_e;

  typedef struct packed {
    logic [1:0] page;
    logic [2:0] dma;
    logic       xmit;
    logic       go;
    logic       halt;
  } cmd_t;
endpackage

// File: rtl/nhr_cmd.sv
module nhr_cmd
  import nhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cr_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             frame_busy,
  input  logic             tx_finish,
  input  logic             ring_drained,
  input  logic             ovw_evt,
  output cmd_t             cr,
  output logic             in_rst,
  output logic             rst_stat,
  output logic             tx_launch,
  output logic             rdma_go,
  output logic [1:0]       rdma_op,
  output logic             rdma_abort
);
  logic       run_q, txp_q, pend_q, inrst_q, ovw_q;
  logic [1:0] page_q;
  logic [2:0] dma_q;
  logic       wr_halt, wr_start, halt_arm, launch_ok;

  assign wr_halt   = cr_we & wdata[0];
  assign wr_start  = cr_we & wdata[1] & ~wdata[0];
  assign halt_arm  = wr_halt | pend_q;
  assign launch_ok = cr_we & wdata[2] & ~wdata[0] & (wdata[1] | run_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      txp_q      <= 1'b0;
      pend_q     <= 1'b0;
      inrst_q    <= 1'b1;
      ovw_q      <= 1'b0;
      page_q     <= PG_0;
      dma_q      <= DMA_IDLE;
      tx_launch  <= 1'b0;
      rdma_go    <= 1'b0;
      rdma_op    <= 2'b00;
      rdma_abort <= 1'b0;
    end else begin
      tx_launch  <= 1'b0;
      rdma_go    <= 1'b0;
      rdma_op    <= 2'b00;
      rdma_abort <= 1'b0;

      if (cr_we) begin
        page_q <= wdata[7:6];
        dma_q  <= wdata[5:3];
        if (wdata[5]) begin
          rdma_abort <= 1'b1;
        end else if (wdata[4:3] != 2'b00) begin
          rdma_go <= 1'b1;
          rdma_op <= wdata[4:3];
        end
      end

      if (wr_halt)       run_q <= 1'b0;
      else if (wr_start) run_q <= 1'b1;

      if (wr_start) begin
        pend_q  <= 1'b0;
        inrst_q <= 1'b0;
      end else if (halt_arm && !frame_busy) begin
        pend_q  <= 1'b0;
        inrst_q <= 1'b1;
      end else if (halt_arm) begin
        pend_q  <= 1'b1;
      end

      if (ovw_evt)                       ovw_q <= 1'b1;
      else if (wr_start || ring_drained) ovw_q <= 1'b0;

      if (launch_ok) begin
        txp_q     <= 1'b1;
        tx_launch <= 1'b1;
      end else if (tx_finish) begin
        txp_q <= 1'b0;
      end
    end
  end

  assign cr       = '{page: page_q, dma: dma_q, xmit: txp_q, go: run_q, halt: ~run_q};
  assign in_rst   = inrst_q;
  assign rst_stat = inrst_q | ovw_q;
endmodule

// File: rtl/nhr_irq.sv
module nhr_irq
  import nhr_pkg::*;
#(
  parameter int NEV = EVT_N
)(
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt,
  input  logic           isr_we,
  input  logic           imr_we,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] isr,
  output logic [NEV-1:0] imr,
  output logic           irq
);
  logic [NEV-1:0] isr_d, imr_d;

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    assign isr_d[i] = evt[i] | (isr[i] & ~(isr_we & wbits[i]));
    always_ff @(posedge clk) begin
      if (rst) isr[i] <= 1'b0;
      else     isr[i] <= isr_d[i];
    end
  end

  assign imr_d = imr_we ? wbits : imr;

  always_ff @(posedge clk) begin
    if (rst) begin
      imr <= '0;
      irq <= 1'b0;
    end else begin
      imr <= imr_d;
      irq <= |(isr_d & imr_d);
    end
  end
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import nhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cs,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [EVT_N-1:0] evt_pulse,
  input  logic             frame_busy,
  input  logic             tx_finish,
  input  logic             ring_drained,
  output logic             irq,
  output logic             ctrl_run,
  output logic             tx_launch,
  output logic             rdma_go,
  output logic [1:0]       rdma_op,
  output logic             rdma_abort
);
  cmd_t             cr;
  page_e            pg;
  logic             wr, rd, cr_we, isr_we, imr_we;
  logic             in_rst, rst_stat, cmd_txp, cmd_run;
  logic [EVT_N-1:0] isr_vec, imr_vec;
  logic [REG_W-1:0] rd_mux;

  assign pg     = page_e'(cr.page);
  assign wr     = bus_cs & bus_we;
  assign rd     = bus_cs & ~bus_we;
  assign cr_we  = wr && (bus_addr == OFS_CMD);
  assign isr_we = wr && (pg == PG_0) && (bus_addr == OFS_STAT);
  assign imr_we = wr && (pg == PG_0) && (bus_addr == OFS_MASK);

  nhr_cmd u_cmd (
    .clk          (clk),
    .rst          (rst),
    .cr_we        (cr_we),
    .wdata        (bus_wdata),
    .frame_busy   (frame_busy),
    .tx_finish    (tx_finish),
    .ring_drained (ring_drained),
    .ovw_evt      (evt_pulse[4]),
    .cr           (cr),
    .in_rst       (in_rst),
    .rst_stat     (rst_stat),
    .tx_launch    (tx_launch),
    .rdma_go      (rdma_go),
    .rdma_op      (rdma_op),
    .rdma_abort   (rdma_abort)
  );

  nhr_irq #(.NEV(EVT_N)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt_pulse),
    .isr_we (isr_we),
    .imr_we (imr_we),
    .wbits  (bus_wdata[EVT_N-1:0]),
    .isr    (isr_vec),
    .imr    (imr_vec),
    .irq    (irq)
  );

  assign cmd_txp  = cr.xmit;
  assign cmd_run  = cr.go;
  assign ctrl_run = cmd_run;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_CMD)
      rd_mux = cr;
    else if (pg == PG_0 && bus_addr == OFS_STAT)
      rd_mux = {rst_stat, isr_vec};
    else if (pg == PG_2 && bus_addr == OFS_MASK)
      rd_mux = {1'b0, imr_vec};
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/nhr_checker.sv
module nhr_checker #(
  parameter int NEV = 7
)(
  input logic           clk,
  input logic           rst,
  input logic           irq,
  input logic           tx_launch,
  input logic           txp,
  input logic           run,
  input logic           in_rst,
  input logic           frame_busy,
  input logic           rdma_go,
  input logic           rdma_abort,
  input logic           isr_we,
  input logic [7:0]     wdata,
  input logic [NEV-1:0] evt,
  input logic [NEV-1:0] isr,
  input logic [NEV-1:0] imr
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rdma_go && rdma_abort)); // R7

  AST_LAUNCH_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    tx_launch |-> txp); // R6

  AST_LAUNCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    tx_launch |-> run); // R6

  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((isr & $past(evt)) == $past(evt))); // R8

  AST_W1C_BIT0: assert property (@(posedge clk) disable iff (rst)
    (isr_we && wdata[0] && !evt[0]) |=> !isr[0]); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (imr == '0) |-> !irq); // R10

  AST_RESET_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(in_rst) |-> !$past(frame_busy)); // R5

  AST_RESET_NOT_RUN: assert property (@(posedge clk) disable iff (rst)
    in_rst |-> !run); // R5
endmodule

bind nic_host_regs nhr_checker #(.NEV(nhr_pkg::EVT_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .tx_launch  (tx_launch),
  .txp        (cmd_txp),
  .run        (cmd_run),
  .in_rst     (in_rst),
  .frame_busy (frame_busy),
  .rdma_go    (rdma_go),
  .rdma_abort (rdma_abort),
  .isr_we     (isr_we),
  .wdata      (bus_wdata),
  .evt        (evt_pulse),
  .isr        (isr_vec),
  .imr        (imr_vec)
);

// File: tb/nic_host_regs_bench.sv
module nic_host_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [6:0] evt_pulse = 7'h00;
  logic       frame_busy = 1'b0, tx_finish = 1'b0, ring_drained = 1'b0;
  logic       irq, ctrl_run, tx_launch, rdma_go, rdma_abort;
  logic [1:0] rdma_op;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nic_host_regs u_nic_host_regs (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .frame_busy(frame_busy), .tx_finish(tx_finish), .ring_drained(ring_drained),
    .irq(irq), .ctrl_run(ctrl_run), .tx_launch(tx_launch), .rdma_go(rdma_go),
    .rdma_op(rdma_op), .rdma_abort(rdma_abort)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit         m_valid = 0;
  bit         m_run, m_txp, m_pend, m_inrst, m_ovw;
  int         m_page, m_dma;
  logic [6:0] m_isr, m_imr;
  logic [7:0] e_rdata;
  bit         e_irq, e_launch, e_go, e_abort;
  logic [1:0] e_op;

  function automatic logic [7:0] model_read(input logic [3:0] a);
    if (a == 4'h0)                  return {2'(m_page), 3'(m_dma), m_txp, m_run, !m_run};
    if (m_page == 0 && a == 4'h7)   return {m_inrst | m_ovw, m_isr};
    if (m_page == 2 && a == 4'hF)   return {1'b0, m_imr};
    return 8'h00;
  endfunction

  always @(posedge clk) begin : mdl
    bit w, cw, hw, sw, lw;
    if (rst) begin
      m_valid = 1; m_run = 0; m_txp = 0; m_pend = 0; m_inrst = 1; m_ovw = 0;
      m_page = 0; m_dma = 4; m_isr = 0; m_imr = 0; e_rdata = 0;
      e_irq = 0; e_launch = 0; e_go = 0; e_abort = 0; e_op = 0;
    end else begin
      w  = bus_cs && bus_we;
      cw = w && bus_addr == 4'h0;
      hw = cw && bus_wdata[0];
      sw = cw && bus_wdata[1] && !bus_wdata[0];
      lw = cw && bus_wdata[2] && !bus_wdata[0] && (bus_wdata[1] || m_run);
      e_launch = 0; e_go = 0; e_abort = 0; e_op = 0;
      if (bus_cs && !bus_we) e_rdata = model_read(bus_addr);
      for (int i = 0; i < 7; i++) begin
        if (evt_pulse[i]) m_isr[i] = 1;
        else if (w && m_page == 0 && bus_addr == 4'h7 && bus_wdata[i]) m_isr[i] = 0;
      end
      if (w && m_page == 0 && bus_addr == 4'hF) m_imr = bus_wdata[6:0];
      if (evt_pulse[4]) m_ovw = 1;
      else if (sw || ring_drained) m_ovw = 0;
      if (sw) begin m_pend = 0; m_inrst = 0; end
      else if ((hw || m_pend) && !frame_busy) begin m_pend = 0; m_inrst = 1; end
      else if (hw || m_pend) m_pend = 1;
      if (hw) m_run = 0; else if (sw) m_run = 1;
      if (lw) begin m_txp = 1; e_launch = 1; end
      else if (tx_finish) m_txp = 0;
      if (cw) begin
        m_page = int'(bus_wdata[7:6]);
        m_dma  = int'(bus_wdata[5:3]);
        if (bus_wdata[5]) e_abort = 1;
        else if (bus_wdata[4:3] != 0) begin e_go = 1; e_op = bus_wdata[4:3]; end
      end
      e_irq = |(m_isr & m_imr);
    end
  end

  always @(negedge clk) begin
    if (m_valid && !rst) begin
      check("R10 irq", irq, e_irq);
      check("R6 tx_launch", tx_launch, e_launch);
      check("R7 rdma_go", rdma_go, e_go);
      check("R7 rdma_op", rdma_op, e_op);
      check("R7 rdma_abort", rdma_abort, e_abort);
      check("R4 ctrl_run", ctrl_run, m_run);
      check("R11 bus_rdata", bus_rdata, e_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #2;
    bus_cs = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #2;
    bus_cs = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse_evt(input logic [6:0] e);
    @(posedge clk); #2; evt_pulse = e;
    @(posedge clk); #2; evt_pulse = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1 reset state
    rd_chk(4'h0, 8'h21, "R1 command after reset");
    rd_chk(4'h7, 8'h80, "R1 status after reset");
    check("R1 irq after reset", irq, 1'b0);
    // R4 start
    wr(4'h0, 8'h02);
    rd_chk(4'h0, 8'h02, "R4 command after start");
    rd_chk(4'h7, 8'h00, "R4 status bit7 cleared by start");
    // R10 mask, R2 page select
    wr(4'hF, 8'hFF);
    wr(4'h0, 8'h82);
    rd_chk(4'hF, 8'h7F, "R10 mask readback, bit7 reserved");
    rd_chk(4'h0, 8'h82, "R2 command visible on page 2");
    rd_chk(4'h7, 8'h00, "R3 status absent on page 2");
    // R8 events and write-1-clear
    wr(4'h0, 8'h02);
    pulse_evt(7'h02);
    check("R10 irq from enabled event", irq, 1'b1);
    rd_chk(4'h7, 8'h02, "R8 event sets bit1");
    wr(4'h7, 8'h01);
    rd_chk(4'h7, 8'h02, "R8 writing other bit leaves bit1");
    wr(4'h7, 8'h02);
    rd_chk(4'h7, 8'h00, "R8 write-1 clears bit1");
    // R8 set wins
    @(posedge clk); #2;
    bus_cs = 1; bus_we = 1; bus_addr = 4'h7; bus_wdata = 8'h08; evt_pulse = 7'h08;
    @(posedge clk); #2;
    bus_cs = 0; bus_we = 0; evt_pulse = 0;
    rd_chk(4'h7, 8'h08, "R8 event beats clearing write");
    wr(4'h7, 8'h08);
    // R3 writes on other pages ignored
    pulse_evt(7'h01);
    wr(4'h0, 8'h42);
    wr(4'h7, 8'h01);
    wr(4'h0, 8'h02);
    rd_chk(4'h7, 8'h01, "R3 status write on page 1 ignored");
    wr(4'h0, 8'hC2);
    wr(4'hF, 8'h00);
    rd_chk(4'h3, 8'h00, "R11 unmapped offset reads zero");
    rd_chk(4'h0, 8'hC2, "R2 command on reserved page");
    wr(4'h0, 8'h82);
    rd_chk(4'hF, 8'h7F, "R3 mask write on page 3 ignored");
    wr(4'h0, 8'h02);
    wr(4'h7, 8'h01);
    // R6 transmit
    wr(4'h0, 8'h06);
    rd_chk(4'h0, 8'h06, "R6 transmit pending set");
    @(posedge clk); #2; tx_finish = 1;
    @(posedge clk); #2; tx_finish = 0;
    rd_chk(4'h0, 8'h02, "R6 transmit pending cleared by finish");
    // R7 DMA commands
    wr(4'h0, 8'h0A);
    rd_chk(4'h0, 8'h0A, "R7 remote read command stored");
    wr(4'h0, 8'h12);
    wr(4'h0, 8'h1A);
    wr(4'h0, 8'h22);
    rd_chk(4'h0, 8'h22, "R7 abort command stored");
    wr(4'h0, 8'h02);
    // R5 halt held off by busy frame
    @(posedge clk); #2; frame_busy = 1;
    wr(4'h0, 8'h01);
    rd_chk(4'h0, 8'h01, "R5 halt bit set at once");
    rd_chk(4'h7, 8'h00, "R5 reset status waits for frame");
    @(posedge clk); #2; frame_busy = 0;
    rd_chk(4'h7, 8'h80, "R5 reset status after frame ends");
    // R5 halt beats start
    wr(4'h0, 8'h02);
    wr(4'h0, 8'h03);
    rd_chk(4'h0, 8'h01, "R5 halt has priority over start");
    rd_chk(4'h7, 8'h80, "R5 reset reached when idle");
    // R6 transmit ignored while halted
    wr(4'h0, 8'h04);
    rd_chk(4'h0, 8'h01, "R6 transmit ignored while halted");
    // R9 overwrite
    wr(4'h0, 8'h02);
    pulse_evt(7'h10);
    rd_chk(4'h7, 8'h90, "R9 overwrite sets bits 4 and 7");
    wr(4'h7, 8'h80);
    rd_chk(4'h7, 8'h90, "R9 bit7 not host writable");
    @(posedge clk); #2; ring_drained = 1;
    @(posedge clk); #2; ring_drained = 0;
    rd_chk(4'h7, 8'h10, "R9 drain clears bit7");
    wr(4'h7, 8'h10);
    rd_chk(4'h7, 8'h00, "R8 bit4 cleared");
    wr(4'h0, 8'h01);
    repeat (2) @(posedge clk);
    @(posedge clk); #2; ring_drained = 1;
    @(posedge clk); #2; ring_drained = 0;
    rd_chk(4'h7, 8'h80, "R9 drain keeps bit7 while in reset");
    repeat (4) @(posedge clk);
    summary();
  end
endmodule